// File: doc/BRIEF.md
# Dual-Channel GPIO Controller with Change Interrupts

This block is a register-mapped general purpose I/O peripheral with up to two channels. Each channel has its own pin count, an output data register and a per-bit direction register. A direction bit of 1 makes the pin an input, so its output enable is released. Parameters set the reset values of both registers. Parameters can also force a whole channel to input or to output, and that choice overrides the direction register.

Input pins pass through a two-flop synchronizer. When any input-mode bit of a channel changes level, the channel's interrupt status bit is set. The two channels share a single interrupt line, which is gated by a per-channel enable and by a global enable.

Software reaches the block over a simple single-beat register port. A write takes effect at the clock edge where it is sampled. Read data comes back one cycle after the request. The second channel is present only when a dual-channel parameter is set, and the interrupt logic is present only when an interrupt parameter is set.

Top module: `pio_pair`

## Requirements
- R1: After reset, the data register of each channel holds its reset parameter, the direction register holds its reset parameter, the global enable, status and channel enable registers read 0, and `irq` is low.
- R2: `pin_oeN` bit k is the inverse of the effective direction bit k, and `pin_outN` carries the data register.
- R3: A read of a data register returns the synchronized pin level at input bits and the data register at output bits. A pin change is visible in reads no later than 4 cycles after it occurs.
- R4: With a channel's all-inputs parameter set, every bit of that channel is an input and its direction reads all ones. With the all-outputs parameter set, every bit is an output and its direction reads zero. In both cases, writes to the direction register have no effect.
- R5: Register bits at and above a channel's width read 0, and writes to those bits are ignored.
- R6: A level change on an input-mode pin sets the status bit of that channel (bit 0 for channel 1, bit 1 for channel 2). A change on an output-mode pin sets nothing.
- R7: Writing a 1 to a status bit toggles that bit, and writing a 0 leaves it unchanged. A change event in the same cycle as the write wins, so the bit ends at 1.
- R8: `irq` is high exactly when bit 31 of the global enable register is 1 and some channel has both its status bit and its enable bit (bit 0 for channel 1, bit 1 for channel 2) set.
- R9: With the dual-channel parameter at 0, the channel 2 registers read 0, writes to them have no effect, `pin_out2` and `pin_oe2` are 0, and status bit 1 never sets.
- R10: With the interrupt parameter at 0, `irq` stays low and the global enable, status and channel enable registers read 0.
- R11: Register offsets (byte addresses) are: 0x000 channel 1 data, 0x004 channel 1 direction, 0x008 channel 2 data, 0x00C channel 2 direction, 0x11C global enable, 0x120 status, 0x128 channel enables. Other offsets read 0. A read sampled at one edge returns its data with `bus_rvalid` high in the following cycle, and `bus_rvalid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one beat |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pin_in1 | input | W1 | Channel 1 pin levels |
| pin_out1 | output | W1 | Channel 1 output values |
| pin_oe1 | output | W1 | Channel 1 output enables |
| pin_in2 | input | W2 | Channel 2 pin levels |
| pin_out2 | output | W2 | Channel 2 output values |
| pin_oe2 | output | W2 | Channel 2 output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a pin change that must not raise anything. This happens when a pin is in output mode, or when the interrupt is masked by one of the two enable levels while the status bit is set. The stimulus first configures a mixed direction pattern and gets a real input change latched. It then flips only the output-mode pins and watches both the status read and `irq`. It walks the global enable and the channel enables separately around a set status bit, and it toggles a clear status bit on purpose to show that a 1-write sets it again. A second instance, built single-channel, without interrupt logic and forced to all outputs, shares the same bus, so every access also checks the absent features.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
  localparam int unsigned REGW   = 32;
  localparam int unsigned ADDR_W = 9;

  localparam logic [ADDR_W-1:0] OFS_DATA1 = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_DIR1  = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_DATA2 = 9'h008;
  localparam logic [ADDR_W-1:0] OFS_DIR2  = 9'h00C;
  localparam logic [ADDR_W-1:0] OFS_GIE   = 9'h11C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 9'h120;
  localparam logic [ADDR_W-1:0] OFS_IER   = 9'h128;
  localparam int unsigned       GIE_BIT   = 31;

  // Readback for a data register: pins where input, register where output.
  function automatic logic [REGW-1:0] mix_read(logic [REGW-1:0] pins,
                                               logic [REGW-1:0] dout,
                                               logic [REGW-1:0] dir);
    return (pins & dir) | (dout & ~dir);
  endfunction

  // Status update: 1-writes toggle, fresh events set with priority.
  function automatic logic [1:0] next_status(logic [1:0] cur,
                                             logic [1:0] tog,
                                             logic [1:0] evt);
    return (cur ^ tog) | evt;
  endfunction
endpackage

// File: rtl/pio_chan.sv
`timescale 1ns/1ps
module pio_chan #(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] DOUT_RST = '0,
  parameter logic [W-1:0] DIR_RST  = '1,
  parameter bit          ALL_IN   = 1'b0,
  parameter bit          ALL_OUT  = 1'b0,
  parameter bit          PRESENT  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data_en,
  input  logic         wr_dir_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir,
  output logic         chg_evt
);
  import pio_pkg::*;

  generate
    if (PRESENT) begin : g_on
      logic [W-1:0] dout_q, dir_q, sync1_q, sync2_q, prev_q, dir_eff;

      always_comb begin
        if (ALL_IN)       dir_eff = '1;
        else if (ALL_OUT) dir_eff = '0;
        else              dir_eff = dir_q;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          dout_q  <= DOUT_RST;
          dir_q   <= DIR_RST;
          sync1_q <= '0;
          sync2_q <= '0;
          prev_q  <= '0;
        end else begin
          if (wr_data_en) dout_q <= wdata;
          if (wr_dir_en)  dir_q  <= wdata;
          sync1_q <= pin_in;
          sync2_q <= sync1_q;
          prev_q  <= sync2_q;
        end
      end

      logic [REGW-1:0] mixed;
      assign mixed   = mix_read(REGW'(sync2_q), REGW'(dout_q), REGW'(dir_eff));
      assign rd_data = mixed[W-1:0];
      assign rd_dir  = dir_eff;
      assign pin_out = dout_q;
      assign pin_oe  = ~dir_eff;
      assign chg_evt = |((sync2_q ^ prev_q) & dir_eff);
    end else begin : g_off
      logic unused_in;
      assign unused_in = ^{wr_data_en, wr_dir_en, wdata, pin_in, clk, rst_n};
      assign rd_data = '0;
      assign rd_dir  = '0;
      assign pin_out = '0;
      assign pin_oe  = '0;
      assign chg_evt = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pio_irq.sv
`timescale 1ns/1ps
module pio_irq #(
  parameter bit PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] evt,
  input  logic       gie_wr,
  input  logic       stat_wr,
  input  logic       ier_wr,
  input  logic       wbit_gie,
  input  logic [1:0] wlo,
  output logic       gie,
  output logic [1:0] stat,
  output logic [1:0] ier,
  output logic       irq
);
  import pio_pkg::*;

  generate
    if (PRESENT) begin : g_on
      logic       gie_q;
      logic [1:0] stat_q, ier_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          gie_q  <= 1'b0;
          stat_q <= '0;
          ier_q  <= '0;
        end else begin
          if (gie_wr) gie_q <= wbit_gie;
          if (ier_wr) ier_q <= wlo;
          stat_q <= next_status(stat_q, stat_wr ? wlo : 2'b00, evt);
        end
      end
      assign gie  = gie_q;
      assign stat = stat_q;
      assign ier  = ier_q;
      assign irq  = gie_q & |(stat_q & ier_q);
    end else begin : g_off
      logic unused_in;
      assign unused_in = ^{clk, rst_n, evt, gie_wr, stat_wr, ier_wr, wbit_gie, wlo};
      assign gie  = 1'b0;
      assign stat = '0;
      assign ier  = '0;
      assign irq  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pio_pair.sv
`timescale 1ns/1ps
module pio_pair #(
  parameter int unsigned W1        = 32,
  parameter int unsigned W2        = 32,
  parameter bit          DUAL      = 1'b1,
  parameter bit          IRQ_ON    = 1'b1,
  parameter logic [31:0] DOUT_RST1 = 32'h0,
  parameter logic [31:0] DOUT_RST2 = 32'h0,
  parameter logic [31:0] DIR_RST1  = 32'hFFFF_FFFF,
  parameter logic [31:0] DIR_RST2  = 32'hFFFF_FFFF,
  parameter bit          ALL_IN1   = 1'b0,
  parameter bit          ALL_IN2   = 1'b0,
  parameter bit          ALL_OUT1  = 1'b0,
  parameter bit          ALL_OUT2  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [8:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_rvalid,
  input  logic [W1-1:0] pin_in1,
  output logic [W1-1:0] pin_out1,
  output logic [W1-1:0] pin_oe1,
  input  logic [W2-1:0] pin_in2,
  output logic [W2-1:0] pin_out2,
  output logic [W2-1:0] pin_oe2,
  output logic          irq
);
  import pio_pkg::*;

  logic wr;
  assign wr = bus_req & bus_we;

  logic [W1-1:0] rd_data1, rd_dir1;
  logic [W2-1:0] rd_data2, rd_dir2;
  logic [1:0]    chg_evt;
  logic          gie;
  logic [1:0]    stat, ier;

  pio_chan #(.W(W1), .DOUT_RST(DOUT_RST1[W1-1:0]), .DIR_RST(DIR_RST1[W1-1:0]),
             .ALL_IN(ALL_IN1), .ALL_OUT(ALL_OUT1), .PRESENT(1'b1)) u_ch1 (
    .clk(clk), .rst_n(rst_n),
    .wr_data_en(wr && bus_addr == OFS_DATA1),
    .wr_dir_en (wr && bus_addr == OFS_DIR1),
    .wdata(bus_wdata[W1-1:0]), .pin_in(pin_in1),
    .pin_out(pin_out1), .pin_oe(pin_oe1),
    .rd_data(rd_data1), .rd_dir(rd_dir1), .chg_evt(chg_evt[0]));

  pio_chan #(.W(W2), .DOUT_RST(DOUT_RST2[W2-1:0]), .DIR_RST(DIR_RST2[W2-1:0]),
             .ALL_IN(ALL_IN2), .ALL_OUT(ALL_OUT2), .PRESENT(DUAL)) u_ch2 (
    .clk(clk), .rst_n(rst_n),
    .wr_data_en(wr && bus_addr == OFS_DATA2),
    .wr_dir_en (wr && bus_addr == OFS_DIR2),
    .wdata(bus_wdata[W2-1:0]), .pin_in(pin_in2),
    .pin_out(pin_out2), .pin_oe(pin_oe2),
    .rd_data(rd_data2), .rd_dir(rd_dir2), .chg_evt(chg_evt[1]));

  pio_irq #(.PRESENT(IRQ_ON)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(chg_evt),
    .gie_wr (wr && bus_addr == OFS_GIE),
    .stat_wr(wr && bus_addr == OFS_STAT),
    .ier_wr (wr && bus_addr == OFS_IER),
    .wbit_gie(bus_wdata[GIE_BIT]), .wlo(bus_wdata[1:0]),
    .gie(gie), .stat(stat), .ier(ier), .irq(irq));

  logic [REGW-1:0] rd_next;
  always_comb begin
    case (bus_addr)
      OFS_DATA1: rd_next = REGW'(rd_data1);
      OFS_DIR1:  rd_next = REGW'(rd_dir1);
      OFS_DATA2: rd_next = REGW'(rd_data2);
      OFS_DIR2:  rd_next = REGW'(rd_dir2);
      OFS_GIE:   rd_next = {gie, 31'b0};
      OFS_STAT:  rd_next = {30'b0, stat};
      OFS_IER:   rd_next = {30'b0, ier};
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req & ~bus_we;
      if (bus_req && !bus_we) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/pio_pair_chk.sv
`timescale 1ns/1ps
module pio_pair_chk #(
  parameter bit DUAL   = 1'b1,
  parameter bit IRQ_ON = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic [8:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_rvalid,
  input logic        irq,
  input logic [1:0]  stat,
  input logic [1:0]  chg_evt
);
  import pio_pkg::*;

  logic unused_chk;
  assign unused_chk = ^bus_wdata[31:1];

  logic clr0;
  assign clr0 = bus_req && bus_we && bus_addr == OFS_STAT && bus_wdata[0];

  a_r6_event_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (IRQ_ON && chg_evt[0]) |=> stat[0]);

  a_r7_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_evt[0] && !clr0) |=> (stat[0] == $past(stat[0])));

  a_r9_no_second_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!DUAL) |-> !stat[1]);

  a_r10_irq_low_without_logic: assert property (@(posedge clk) disable iff (!rst_n)
    (!IRQ_ON) |-> !irq);

  a_r11_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);
endmodule

bind pio_pair pio_pair_chk #(.DUAL(DUAL), .IRQ_ON(IRQ_ON)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .irq(irq), .stat(stat), .chg_evt(chg_evt));

// File: tb/pio_pair_bench.sv
`timescale 1ns/1ps
module pio_pair_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] a_in1 = '0;
  logic [7:0]  a_in2 = '0;
  logic [7:0]  b_in1 = '0;
  logic [31:0] b_in2 = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_rvalid, b_rvalid, a_irq, b_irq;
  logic [15:0] a_out1, a_oe1;
  logic [7:0]  a_out2, a_oe2, b_out1, b_oe1;
  logic [31:0] b_out2, b_oe2;

  // A: dual channel with interrupts, channel 2 forced to inputs.
  pio_pair #(.W1(16), .W2(8), .DUAL(1'b1), .IRQ_ON(1'b1),
             .DOUT_RST1(32'h00F0), .DIR_RST1(32'hFF00),
             .DOUT_RST2(32'h3C), .ALL_IN2(1'b1)) u_pio_pair (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(a_rdata),
    .bus_rvalid(a_rvalid), .pin_in1(a_in1), .pin_out1(a_out1), .pin_oe1(a_oe1),
    .pin_in2(a_in2), .pin_out2(a_out2), .pin_oe2(a_oe2), .irq(a_irq));

  // B: single channel, no interrupt logic, channel 1 forced to outputs.
  pio_pair #(.W1(8), .DUAL(1'b0), .IRQ_ON(1'b0),
             .DOUT_RST1(32'h5A), .ALL_OUT1(1'b1)) u_pio_pair_b (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(b_rdata),
    .bus_rvalid(b_rvalid), .pin_in1(b_in1), .pin_out1(b_out1), .pin_oe1(b_oe1),
    .pin_in2(b_in2), .pin_out2(b_out2), .pin_oe2(b_oe2), .irq(b_irq));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard queues filled by the driver, drained by the monitor.
  logic [31:0] qa[$], qb[$];
  string       qt[$];

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [8:0] a, logic [31:0] ea, logic [31:0] eb);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    qa.push_back(ea); qb.push_back(eb); qt.push_back(tag);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (a_rvalid || b_rvalid) begin
      if (qt.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", a_rdata);
      end else begin
        string t;
        logic [31:0] ea, eb;
        t = qt.pop_front(); ea = qa.pop_front(); eb = qb.pop_front();
        check({t, " A"}, a_rdata, ea);
        check({t, " B"}, b_rdata, eb);
        check({t, " R11 rvalid"}, {30'b0, a_rvalid, b_rvalid}, 32'h3);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 / R2 / R4 reset state at the pins
    check("R1 A irq", {31'b0, a_irq}, 0);
    check("R1 B irq", {31'b0, b_irq}, 0);
    check("R2 A oe1", {16'b0, a_oe1}, 32'h00FF);
    check("R1 A out1", {16'b0, a_out1}, 32'h00F0);
    check("R4 B oe1 all outputs", {24'b0, b_oe1}, 32'hFF);
    check("R9 B oe2/out2", b_oe2 | b_out2, 0);
    check("R4 A oe2 all inputs", {24'b0, a_oe2}, 0);
    // R1 register reset values, R11 offsets
    rd("R1 data1", 9'h000, 32'h00F0, 32'h5A);
    rd("R1 dir1",  9'h004, 32'hFF00, 32'h0);
    rd("R9 data2", 9'h008, 32'h0,    32'h0);
    rd("R4 dir2",  9'h00C, 32'hFF,   32'h0);
    rd("R1 gie",   9'h11C, 0, 0);
    rd("R1 stat",  9'h120, 0, 0);
    rd("R1 ier",   9'h128, 0, 0);
    rd("R11 unmapped", 9'h010, 0, 0);
    // R5 width truncation
    wr(9'h000, 32'hFFFF_1234);
    rd("R5 data1 wide write", 9'h000, 32'h0034, 32'h34);
    check("R2 A out1", {16'b0, a_out1}, 32'h1234);
    // R2 / R4 direction
    wr(9'h004, 32'hFFFF_0F0F);
    rd("R5 dir1", 9'h004, 32'h0F0F, 32'h0);
    check("R2 A oe1 after dir write", {16'b0, a_oe1}, 32'hF0F0);
    // R3 / R6 input change on input-mode bits
    @(negedge clk); a_in1 = 16'hAAAA;
    idle(5);
    rd("R3 data1 mixed", 9'h000, 32'h1A3A, 32'h34);
    rd("R6 stat ch1", 9'h120, 32'h1, 0);
    check("R8 irq gated by gie", {31'b0, a_irq}, 0);
    // R8 enables
    wr(9'h128, 32'h3);
    check("R8 irq without gie", {31'b0, a_irq}, 0);
    wr(9'h11C, 32'h8000_0000);
    check("R8 irq raised", {31'b0, a_irq}, 1);
    check("R10 B irq", {31'b0, b_irq}, 0);
    rd("R10 gie read", 9'h11C, 32'h8000_0000, 0);
    // R7 clear semantics
    wr(9'h120, 32'h0);
    rd("R7 zero write keeps", 9'h120, 32'h1, 0);
    wr(9'h120, 32'h1);
    rd("R7 one write clears", 9'h120, 32'h0, 0);
    check("R8 irq after clear", {31'b0, a_irq}, 0);
    // R6 output-mode pins do not trigger
    @(negedge clk); a_in1 = 16'hAAAA ^ 16'hF0F0;
    idle(5);
    rd("R6 output pins ignored", 9'h120, 32'h0, 0);
    check("R6 irq after output-pin change", {31'b0, a_irq}, 0);
    // Channel 2 events and forced inputs
    @(negedge clk); a_in2 = 8'h01; b_in2 = 32'hFFFF_FFFF;
    idle(5);
    rd("R6 stat ch2", 9'h120, 32'h2, 0);
    check("R8 irq from ch2", {31'b0, a_irq}, 1);
    wr(9'h00C, 32'h0);
    rd("R4 dir2 write ignored", 9'h00C, 32'hFF, 0);
    wr(9'h008, 32'h55);
    rd("R3 data2 input levels", 9'h008, 32'h01, 0);
    check("R9 B out2 after write", b_out2, 0);
    check("R4 A oe2 after dir write", {24'b0, a_oe2}, 0);
    // R8 per-channel enable masks ch2
    wr(9'h128, 32'h1);
    check("R8 ch2 masked", {31'b0, a_irq}, 0);
    // R7 toggle from 0 sets, then clear both
    wr(9'h120, 32'h1);
    rd("R7 toggle sets", 9'h120, 32'h3, 0);
    check("R8 ch1 enabled after toggle", {31'b0, a_irq}, 1);
    wr(9'h120, 32'h3);
    rd("R7 both cleared", 9'h120, 32'h0, 0);
    wr(9'h11C, 32'h0);
    check("R8 gie off", {31'b0, a_irq}, 0);
    idle(3);
    check("R11 queue drained", qt.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule